// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Burst Addressing

This block is a word-addressed RAM with two symmetric ports, A and B. Either port can read or write any word in any cycle, with no arbitration between them. Every port input is captured in a register on the rising clock edge. The access then runs in the cycle that follows that edge. Both ports share one clock and one synchronous active-high reset. Apart from that, all of their controls are separate.

Each port chooses its access address in one of two ways. It can load the registered external address, or it can use an internal burst counter. The counter can be cleared, loaded, stepped by one or held, so a port can stream through consecutive words with one access per cycle. Each port also chooses its read path with a static mode input:

- **Flow-through:** the word read from the array is presented in the access cycle.
- **Pipelined:** the word passes through one more register and is presented one cycle later.

Two chip enables gate each port. A deselected port neither writes nor presents data. In pipelined mode a reselected port needs one full selected cycle before its data output becomes valid again. A per-port valid flag qualifies the read data. The flag is high only for read accesses while output enable is active.

Top module: `dpram_burst`

## Requirements
- R1: In the same cycle, ports A and B each perform their own access (read or write) at any word, and neither port's access changes the other port's result. The one exception is two writes to one word in one cycle, which leave that word's content undefined.
- R2: A port with its enables active and x_wr_n low (0 = write, 1 = read) stores x_wdata at its access address. Either port reads that word back in any later cycle.
- R3: With x_flow_thru = 1, a read whose inputs were captured at edge k presents its word with x_rvalid high during the cycle after edge k. With x_flow_thru = 0, the same word is presented one cycle later, after edge k+1.
- R4: When x_ads_n is low (active low), the access address for that cycle is the captured x_addr, and the counter takes that value.
- R5: When x_cnten_n is low and neither x_cntrst_n nor x_ads_n is low, the access address is the counter value plus one, and the counter takes that value. When all three are high, the counter holds and the same word is accessed again.
- R6: The counter spans all 2**ADDR_W words, and stepping from the highest address gives address 0.
- R7: When x_cntrst_n is low, the access address is 0 and the counter becomes 0, whatever x_ads_n and x_cnten_n are. Address load takes priority over stepping.
- R8: A port is selected only while x_ce0_n is low and x_ce1 is high. A deselected cycle writes nothing and presents no valid data.
- R9: In pipelined mode, after a deselected cycle the port's first selected read cycle gives no valid output. Valid output resumes one cycle later.
- R10: While x_oe_n is high, x_rvalid is low. Whenever x_rvalid is low, x_rdata is all zeros.
- R11: A reset cycle clears both burst counters to 0 and drives both x_rvalid low.
- R12: A write access never raises the port's x_rvalid for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | ADDR_W | Port A external address |
| a_ads_n | input | 1 | Port A address load, active low |
| a_cnten_n | input | 1 | Port A counter step, active low |
| a_cntrst_n | input | 1 | Port A counter clear, active low |
| a_ce0_n | input | 1 | Port A primary enable, active low |
| a_ce1 | input | 1 | Port A secondary enable, active high |
| a_wr_n | input | 1 | Port A direction, 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_flow_thru | input | 1 | Port A read path, 1 = flow-through, 0 = pipelined |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| b_addr | input | ADDR_W | Port B external address |
| b_ads_n | input | 1 | Port B address load, active low |
| b_cnten_n | input | 1 | Port B counter step, active low |
| b_cntrst_n | input | 1 | Port B counter clear, active low |
| b_ce0_n | input | 1 | Port B primary enable, active low |
| b_ce1 | input | 1 | Port B secondary enable, active high |
| b_wr_n | input | 1 | Port B direction, 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_flow_thru | input | 1 | Port B read path, 1 = flow-through, 0 = pipelined |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
Two situations are hard to reach by chance.

- **Counter wrap.** A random counter almost never reaches the top of the address space. A directed burst therefore loads the address two below the top, writes four words across the wrap, and reads them back with the other port.
- **Pipelined recovery.** The recovery cycle only shows when a deselected cycle lands between pipelined reads. The random phase therefore drops each enable on its own now and then while the ports sit in pipelined mode, and it narrows the address range so that both ports meet on the same words.

The bench model marks a word written by both ports in one cycle as unknown and skips data checks on it until the word is rewritten.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NPORTS = 2;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_STEP = 2'd1,
        CTR_LOAD = 2'd2,
        CTR_ZERO = 2'd3
    } ctr_op_e;

    // clear beats load, load beats step, step beats hold
    function automatic ctr_op_e ctr_decode(input logic clr_n,
                                           input logic load_n,
                                           input logic step_n);
        if (!clr_n)  return CTR_ZERO;
        if (!load_n) return CTR_LOAD;
        if (!step_n) return CTR_STEP;
        return CTR_HOLD;
    endfunction

    function automatic logic port_selected(input logic en0_n, input logic en1);
        return (!en0_n) && en1;
    endfunction

endpackage

// File: rtl/dpr_in_stage.sv
module dpr_in_stage
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ads_n,
    input  logic              cnten_n,
    input  logic              cntrst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output ctr_op_e           op_q,
    output logic              sel_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] wdata_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        ctr_op_e           op;
        logic              sel;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } in_reg_t;

    in_reg_t cap_d, cap_q;

    always_comb begin
        cap_d.addr  = addr;
        cap_d.op    = ctr_decode(cntrst_n, ads_n, cnten_n);
        cap_d.sel   = port_selected(ce0_n, ce1);
        cap_d.wr    = !wr_n;
        cap_d.wdata = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q.addr  <= '0;
            cap_q.op    <= CTR_HOLD;
            cap_q.sel   <= 1'b0;
            cap_q.wr    <= 1'b0;
            cap_q.wdata <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_q  = cap_q.addr;
    assign op_q    = cap_q.op;
    assign sel_q   = cap_q.sel;
    assign wr_q    = cap_q.wr;
    assign wdata_q = cap_q.wdata;

endmodule

// File: rtl/dpr_burst_ctr.sv
module dpr_burst_ctr
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctr_op_e           op,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [ADDR_W-1:0] cnt_q;

    always_comb begin
        unique case (op)
            CTR_ZERO: eff_addr = '0;
            CTR_LOAD: eff_addr = load_addr;
            CTR_STEP: eff_addr = cnt_q + ADDR_W'(1);
            default:  eff_addr = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= eff_addr;
    end

    a_r5_hold_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_HOLD) |=> (cnt_q == $past(cnt_q)));

    // R6: the width-limited add wraps the top address to zero
    a_r5_step_adds_one: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_STEP) |=> (cnt_q == $past(cnt_q) + ADDR_W'(1)));

    a_r7_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        (op == CTR_ZERO) |=> (cnt_q == '0));

endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic [NPORTS-1:0]              we,
    input  logic [NPORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NPORTS-1:0][DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // a clash on one word resolves to the higher port; callers treat it as undefined
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (we[p]) mem[addr[p]] <= wdata[p];
        end
    end

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            rdata[p] = mem[addr[p]];
        end
    end

endmodule

// File: rtl/dpr_read_path.sv
module dpr_read_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flow_thru,
    input  logic              oe_n,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] arr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] pipe_d_q;
    logic              pipe_v_q;
    logic              path_v;
    logic [DATA_W-1:0] path_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_d_q <= '0;
            pipe_v_q <= 1'b0;
        end else begin
            pipe_d_q <= arr_q;
            pipe_v_q <= acc_rd;
        end
    end

    assign path_v = flow_thru ? acc_rd : pipe_v_q;
    assign path_d = flow_thru ? arr_q  : pipe_d_q;
    assign rvalid = path_v && !oe_n;
    assign rdata  = rvalid ? path_d : '0;

    a_r10_oe_blocks_output: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!rvalid && (rdata == '0)));

    a_r9_pipe_needs_prior_read: assert property (@(posedge clk) disable iff (rst)
        (!flow_thru && !$past(acc_rd)) |-> !rvalid);

    a_r3_pipe_one_cycle_late: assert property (@(posedge clk) disable iff (rst)
        (!flow_thru && rvalid) |-> (rdata == $past(arr_q)));

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_ads_n,
    input  logic              a_cnten_n,
    input  logic              a_cntrst_n,
    input  logic              a_ce0_n,
    input  logic              a_ce1,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic              a_flow_thru,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_ads_n,
    input  logic              b_cnten_n,
    input  logic              b_cntrst_n,
    input  logic              b_ce0_n,
    input  logic              b_ce1,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic              b_flow_thru,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);

    logic [NPORTS-1:0][ADDR_W-1:0] pin_addr;
    logic [NPORTS-1:0]             pin_ads_n, pin_cnten_n, pin_cntrst_n;
    logic [NPORTS-1:0]             pin_ce0_n, pin_ce1, pin_wr_n, pin_oe_n, pin_ft;
    logic [NPORTS-1:0][DATA_W-1:0] pin_wdata;
    logic [NPORTS-1:0][DATA_W-1:0] prt_rdata;
    logic [NPORTS-1:0]             prt_rvalid;

    logic [NPORTS-1:0]             arr_we;
    logic [NPORTS-1:0][ADDR_W-1:0] arr_addr;
    logic [NPORTS-1:0][DATA_W-1:0] arr_wdata;
    logic [NPORTS-1:0][DATA_W-1:0] arr_rdata;

    assign pin_addr     = {b_addr, a_addr};
    assign pin_ads_n    = {b_ads_n, a_ads_n};
    assign pin_cnten_n  = {b_cnten_n, a_cnten_n};
    assign pin_cntrst_n = {b_cntrst_n, a_cntrst_n};
    assign pin_ce0_n    = {b_ce0_n, a_ce0_n};
    assign pin_ce1      = {b_ce1, a_ce1};
    assign pin_wr_n     = {b_wr_n, a_wr_n};
    assign pin_oe_n     = {b_oe_n, a_oe_n};
    assign pin_ft       = {b_flow_thru, a_flow_thru};
    assign pin_wdata    = {b_wdata, a_wdata};

    assign a_rdata  = prt_rdata[0];
    assign a_rvalid = prt_rvalid[0];
    assign b_rdata  = prt_rdata[1];
    assign b_rvalid = prt_rvalid[1];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [ADDR_W-1:0] addr_q;
        ctr_op_e           op_q;
        logic              sel_q;
        logic              wr_q;
        logic [DATA_W-1:0] wdata_q;

        dpr_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
            .clk      (clk),
            .rst      (rst),
            .addr     (pin_addr[p]),
            .ads_n    (pin_ads_n[p]),
            .cnten_n  (pin_cnten_n[p]),
            .cntrst_n (pin_cntrst_n[p]),
            .ce0_n    (pin_ce0_n[p]),
            .ce1      (pin_ce1[p]),
            .wr_n     (pin_wr_n[p]),
            .wdata    (pin_wdata[p]),
            .addr_q   (addr_q),
            .op_q     (op_q),
            .sel_q    (sel_q),
            .wr_q     (wr_q),
            .wdata_q  (wdata_q)
        );

        dpr_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .op        (op_q),
            .load_addr (addr_q),
            .eff_addr  (arr_addr[p])
        );

        assign arr_we[p]    = sel_q && wr_q && !rst;
        assign arr_wdata[p] = wdata_q;

        dpr_read_path #(.DATA_W(DATA_W)) u_rd (
            .clk       (clk),
            .rst       (rst),
            .flow_thru (pin_ft[p]),
            .oe_n      (pin_oe_n[p]),
            .acc_rd    (sel_q && !wr_q),
            .arr_q     (arr_rdata[p]),
            .rdata     (prt_rdata[p]),
            .rvalid    (prt_rvalid[p])
        );

        a_r8_deselect_no_write: assert property (@(posedge clk) disable iff (rst)
            !sel_q |-> !arr_we[p]);

        a_r12_write_not_valid: assert property (@(posedge clk) disable iff (rst)
            (pin_ft[p] && sel_q && wr_q) |-> !prt_rvalid[p]);
    end

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (arr_wdata),
        .rdata (arr_rdata)
    );

endmodule

// File: tb/dpram_burst_tb.sv
module dpram_burst_tb_top;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [AW-1:0] i_addr     [2];
    logic          i_ads_n    [2];
    logic          i_cnten_n  [2];
    logic          i_cntrst_n [2];
    logic          i_ce0_n    [2];
    logic          i_ce1      [2];
    logic          i_wr_n     [2];
    logic          i_oe_n     [2];
    logic          i_ft       [2];
    logic [DW-1:0] i_wdata    [2];
    logic [DW-1:0] o_rdata    [2];
    logic          o_rvalid   [2];

    dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .a_addr(i_addr[0]), .a_ads_n(i_ads_n[0]), .a_cnten_n(i_cnten_n[0]),
        .a_cntrst_n(i_cntrst_n[0]), .a_ce0_n(i_ce0_n[0]), .a_ce1(i_ce1[0]),
        .a_wr_n(i_wr_n[0]), .a_oe_n(i_oe_n[0]), .a_flow_thru(i_ft[0]),
        .a_wdata(i_wdata[0]), .a_rdata(o_rdata[0]), .a_rvalid(o_rvalid[0]),
        .b_addr(i_addr[1]), .b_ads_n(i_ads_n[1]), .b_cnten_n(i_cnten_n[1]),
        .b_cntrst_n(i_cntrst_n[1]), .b_ce0_n(i_ce0_n[1]), .b_ce1(i_ce1[1]),
        .b_wr_n(i_wr_n[1]), .b_oe_n(i_oe_n[1]), .b_flow_thru(i_ft[1]),
        .b_wdata(i_wdata[1]), .b_rdata(o_rdata[1]), .b_rvalid(o_rvalid[1])
    );

    // reference model state
    logic [DW-1:0] mem_m   [DEPTH];
    bit            known_m [DEPTH];
    logic [AW-1:0] m_cnt   [2];
    bit            m_pw    [2];
    logic [AW-1:0] m_pwa   [2];
    logic [DW-1:0] m_pwd   [2];
    bit            m_ftv   [2];
    logic [DW-1:0] m_ftd   [2];
    bit            m_ftk   [2];
    bit            m_pv    [2];
    logic [DW-1:0] m_pd    [2];
    bit            m_pk    [2];

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    bit    done = 0;

    function automatic logic [AW-1:0] next_addr(int p);
        if (!i_cntrst_n[p]) return '0;
        if (!i_ads_n[p])    return i_addr[p];
        if (!i_cnten_n[p])  return m_cnt[p] + AW'(1);
        return m_cnt[p];
    endfunction

    task automatic model_edge();
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                m_cnt[p] = '0; m_pw[p] = 0; m_ftv[p] = 0; m_pv[p] = 0;
                m_ftd[p] = '0; m_pd[p] = '0; m_ftk[p] = 0; m_pk[p] = 0;
            end
            return;
        end
        if (m_pw[0] && m_pw[1] && (m_pwa[0] == m_pwa[1])) begin
            known_m[m_pwa[0]] = 0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (m_pw[p]) begin
                    mem_m[m_pwa[p]] = m_pwd[p];
                    known_m[m_pwa[p]] = 1;
                end
            end
        end
        for (int p = 0; p < 2; p++) begin
            bit            sel;
            logic [AW-1:0] eff;
            m_pv[p] = m_ftv[p]; m_pd[p] = m_ftd[p]; m_pk[p] = m_ftk[p];
            sel = !i_ce0_n[p] && i_ce1[p];
            eff = next_addr(p);
            m_cnt[p] = eff;
            m_ftv[p] = sel && i_wr_n[p];
            m_ftd[p] = mem_m[eff];
            m_ftk[p] = known_m[eff];
            m_pw[p]  = sel && !i_wr_n[p];
            m_pwa[p] = eff;
            m_pwd[p] = i_wdata[p];
        end
    endtask

    task automatic check_val(string what, int p, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s port %0d %s: actual %0h expected %0h at %0t",
                     cur_req, p, what, got, exp, $time);
        end
    endtask

    task automatic check_outputs();
        for (int p = 0; p < 2; p++) begin
            bit            ev, ek;
            logic [DW-1:0] ed;
            ev = !i_oe_n[p] && (i_ft[p] ? m_ftv[p] : m_pv[p]);
            ek = i_ft[p] ? m_ftk[p] : m_pk[p];
            ed = ev ? (i_ft[p] ? m_ftd[p] : m_pd[p]) : '0;
            check_val("rvalid", p, int'(o_rvalid[p]), int'(ev));
            if (!ev || ek) check_val("rdata", p, int'(o_rdata[p]), int'(ed));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic idle(int p);
        i_ads_n[p] = 1; i_cnten_n[p] = 1; i_cntrst_n[p] = 1;
        i_ce0_n[p] = 0; i_ce1[p] = 1; i_wr_n[p] = 1; i_oe_n[p] = 0;
    endtask

    // burst of n accesses on port p: load at start, then step
    task automatic burst(int p, int start, int n, bit wr, int seed);
        for (int k = 0; k < n; k++) begin
            idle(p);
            i_addr[p]  = AW'(start);
            i_ads_n[p] = (k == 0) ? 1'b0 : 1'b1;
            i_cnten_n[p] = (k == 0) ? 1'b1 : 1'b0;
            i_wr_n[p]  = !wr;
            i_wdata[p] = DW'(seed + 7 * k);
            cycle();
        end
        idle(p);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            known_m[i] = 0;
            mem_m[i] = '0;
        end
        for (int p = 0; p < 2; p++) begin
            idle(p);
            i_addr[p] = '0; i_wdata[p] = '0; i_ft[p] = 1;
        end
        model_edge();

        // R11: reset clears counters and valids
        cur_req = "R11";
        rst = 1;
        repeat (3) cycle();
        rst = 0;
        cycle();
        cycle();

        // R2 / R4 / R5: port A writes a burst, port B reads it flow-through
        cur_req = "R2";
        burst(0, 32, 8, 1, 8'h40);
        cur_req = "R4";
        burst(1, 32, 8, 0, 0);
        cur_req = "R5";
        i_cnten_n[1] = 1; i_ads_n[1] = 1;
        cycle(); cycle();

        // R3: same burst read through the pipelined path
        cur_req = "R3";
        i_ft[1] = 0;
        burst(1, 32, 8, 0, 0);
        cycle();
        i_ft[1] = 1;

        // R6: wrap across the top of the address space
        cur_req = "R6";
        burst(0, DEPTH - 2, 4, 1, 8'h90);
        burst(1, DEPTH - 2, 5, 0, 0);

        // R7: clear beats load and step; load beats step
        cur_req = "R7";
        idle(1);
        i_addr[1] = AW'(35); i_ads_n[1] = 0; i_cnten_n[1] = 0; i_cntrst_n[1] = 0;
        cycle();
        i_cntrst_n[1] = 1;
        cycle();
        i_ads_n[1] = 1;
        cycle();
        idle(1);

        // R8 / R9: deselect in pipelined mode and recover
        cur_req = "R9";
        i_ft[1] = 0;
        burst(1, 33, 3, 0, 0);
        cur_req = "R8";
        i_ce0_n[1] = 1; i_wr_n[1] = 0; i_wdata[1] = 8'hEE;
        cycle();
        i_ce0_n[1] = 0; i_ce1[1] = 0;
        cycle();
        cur_req = "R9";
        idle(1);
        cycle(); cycle(); cycle();
        i_ft[1] = 1;

        // R10: output enable gating
        cur_req = "R10";
        i_oe_n[0] = 1; i_oe_n[1] = 1;
        burst(0, 32, 3, 0, 0);
        cycle();
        idle(0); idle(1);

        // R12: write cycles with flow-through read path
        cur_req = "R12";
        burst(1, 100, 4, 1, 8'h11);
        burst(0, 100, 4, 0, 0);

        // R1: random concurrent traffic on both ports
        cur_req = "R1";
        for (int c = 0; c < 4000; c++) begin
            if (c % 150 == 0) begin
                i_ft[0] = 1'($urandom % 2);
                i_ft[1] = 1'($urandom % 2);
            end
            for (int p = 0; p < 2; p++) begin
                int r;
                r = $urandom % 4;
                i_addr[p]     = (r == 0) ? AW'($urandom) : AW'($urandom % 16);
                i_ads_n[p]    = ($urandom % 10) >= 3;
                i_cnten_n[p]  = ($urandom % 2) == 0;
                i_cntrst_n[p] = ($urandom % 20) != 0;
                i_ce0_n[p]    = ($urandom % 10) == 0;
                i_ce1[p]      = ($urandom % 10) != 0;
                i_wr_n[p]     = ($urandom % 10) >= 4;
                i_oe_n[p]     = ($urandom % 10) == 0;
                i_wdata[p]    = DW'($urandom);
            end
            cycle();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule